// File: doc/BRIEF.md
# Broadcast-Input Convolution Array with Circulating Weights

This block computes a 1-D convolution of a sample stream against K weights. The result is y_i = w_0*x_i + w_1*x_{i+1} + ... + w_{K-1}*x_{i+K-1}, with 0-based indices. It has K multiply-accumulate cells in a line. Each accepted sample is driven to all K cells in the same cycle. The weights step one cell along a ring for every accepted sample. Each cell keeps its own running sum.

A tag bit is stored with a weight and moves with it. When a cell uses the tagged weight, it hands its finished sum to a shared result bus and starts a new sum from the current product. The result leaves through a registered, valid-qualified output. If more than one cell holds a finished result in the same step, the lowest-index cell wins and a collision flag is raised.

Software preloads each cell's weight and tag through a write port. In normal use, weight w_k goes to cell k and the tag goes only on cell 0. The first K samples then produce no result. After that, each accepted sample yields one convolution output.

Top module: `bcast_conv_array`

## Requirements
- R1: During and after synchronous reset `out_valid_o` and `collide_o` are 0 and every cell holds weight 0, tag 0 and sum 0 and is not yet started, so samples fed after reset without any load produce no output.
- R2: With `load_en_i` high, cell `load_idx_i` takes `load_w_i` as its weight and `load_tag_i` as its tag. In the same cycle `sample_valid_i` is not accepted: nothing accumulates, nothing rotates, and `out_valid_o` is 0 in the following cycle.
- R3: A sample is accepted when `sample_valid_i` is high and `load_en_i` is low. It is multiplied by the weight in every cell at once, and every untagged cell adds its product to its sum.
- R4: A cell whose weight is tagged at an accepted sample restarts its sum from that product, discarding the previous sum.
- R5: After each accepted sample, cell j takes the weight and tag that cell (j+1) mod K held.
- R6: Preload w_k into cell k for every k, with the tag only on cell 0. Then the accepted sample with 0-based number t >= K gives `out_valid_o` = 1 with `out_data_o` = y_{t-K} (signed) in the cycle after its accepting edge.
- R7: A tagged cell drives the bus only if it has restarted at least once before. With the preload of R6, the first K accepted samples give no output.
- R8: In a cycle with no accepted sample and no load, every cell's state is unchanged, and `out_valid_o` is 0 in the next cycle. Idle gaps in the stream do not change any result.
- R9: If several started, tagged cells are ready to drive the bus at one accepted sample, the lowest-index cell's sum is output and `collide_o` is 1 for that output cycle. Otherwise `collide_o` is 0.
- R10: Data and weights are signed W-bit values. The sum is a signed value of 2*W + ceil(log2 K) bits (at least one extra bit), so K products of -2^(W-1) * -2^(W-1) are returned exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en_i | input | 1 | Weight preload strobe |
| load_idx_i | input | IDX_W | Cell to preload |
| load_w_i | input | W | Signed weight to preload |
| load_tag_i | input | 1 | Tag bit stored with the weight |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | W | Signed input sample, broadcast to all cells |
| out_valid_o | output | 1 | Result strobe |
| out_data_o | output | ACC_W | Signed finished sum |
| collide_o | output | 1 | More than one cell was ready to drive the bus |

## Verification
The assertions assume that loads and samples are only changed away from the rising edge, and that a load index is always below K. The bench drives every input on the falling edge and uses indices 0 to K-1 only. The cell assertions assume that reset has cleared every register before the first sample. The bench applies reset before each scenario.

The collision assertions hold for any tag pattern. The bench exercises them with a deliberate two-tag preload alongside the normal single-tag preload.

// File: rtl/conv_pkg.sv
package conv_pkg;
  function automatic int clog2_min1(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/conv_cell.sv
module conv_cell
  import conv_pkg::*;
#(
  parameter int W     = 8,
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_i,
  input  logic signed [W-1:0]     ld_w_i,
  input  logic                    ld_tag_i,
  input  logic                    step_i,
  input  logic signed [W-1:0]     x_i,
  input  logic signed [W-1:0]     w_in_i,
  input  logic                    tag_in_i,
  output logic signed [W-1:0]     w_o,
  output logic                    tag_o,
  output logic [ACC_W-1:0]        acc_o,
  output logic                    fire_o
);
  localparam int PW = 2 * W;

  logic signed [W-1:0]     w_q;
  logic                    tag_q;
  logic                    armed_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_ext;

  assign prod     = w_q * x_i;
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q     <= '0;
      tag_q   <= 1'b0;
      armed_q <= 1'b0;
      acc_q   <= '0;
    end else if (ld_i) begin
      w_q   <= ld_w_i;
      tag_q <= ld_tag_i;
    end else if (step_i) begin
      w_q     <= w_in_i;
      tag_q   <= tag_in_i;
      armed_q <= armed_q | tag_q;
      acc_q   <= tag_q ? prod_ext : (acc_q + prod_ext);
    end
  end

  assign w_o    = w_q;
  assign tag_o  = tag_q;
  assign acc_o  = acc_q;
  assign fire_o = step_i & tag_q & armed_q;

  // R4: tagged step restarts from the product alone
  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !ld_i && tag_q) |=> (acc_q == $past(prod_ext)));

  // R3: untagged step adds the product
  assert_accumulate_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !ld_i && !tag_q) |=> (acc_q == $past(acc_q) + $past(prod_ext)));

  // R8: idle cycle leaves cell state alone
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !ld_i) |=> ($stable(acc_q) && $stable(w_q) && $stable(tag_q) && $stable(armed_q)));

  // R5: weight arrives from the neighbour on a step
  assert_rotate_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && !ld_i) |=> (w_q == $past(w_in_i) && tag_q == $past(tag_in_i)));
endmodule

// File: rtl/conv_bus_arb.sv
module conv_bus_arb #(
  parameter int N     = 4,
  parameter int ACC_W = 18
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0]              fire_i,
  input  logic [N-1:0][ACC_W-1:0]   acc_i,
  output logic                      any_o,
  output logic [ACC_W-1:0]          data_o,
  output logic                      multi_o
);
  logic [N-1:0] grant;

  always_comb begin
    grant  = '0;
    data_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fire_i[i]) begin
        grant  = '0;
        grant[i] = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (grant[i]) data_o = acc_i[i];
    end
  end

  assign any_o   = |fire_i;
  assign multi_o = ($countones(fire_i) > 1);

  // R9: at most one cell owns the bus
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R9: a request always results in a grant
  assert_grant_given_R9: assert property (@(posedge clk) disable iff (rst)
    (|fire_i) |-> (|grant));
endmodule

// File: rtl/bcast_conv_array.sv
module bcast_conv_array
  import conv_pkg::*;
#(
  parameter int W     = 8,
  parameter int K     = 4,
  parameter int IDX_W = clog2_min1(K),
  parameter int ACC_W = 2 * W + clog2_min1(K)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_en_i,
  input  logic [IDX_W-1:0]        load_idx_i,
  input  logic signed [W-1:0]     load_w_i,
  input  logic                    load_tag_i,
  input  logic                    sample_valid_i,
  input  logic signed [W-1:0]     sample_i,
  output logic                    out_valid_o,
  output logic signed [ACC_W-1:0] out_data_o,
  output logic                    collide_o
);
  logic                         step;
  logic [K-1:0][W-1:0]          w_ring;
  logic [K-1:0]                 tag_ring;
  logic [K-1:0][ACC_W-1:0]      acc_all;
  logic [K-1:0]                 fire;
  logic                         bus_any;
  logic [ACC_W-1:0]             bus_data;
  logic                         bus_multi;

  assign step = sample_valid_i & ~load_en_i;

  for (genvar j = 0; j < K; j++) begin : g_cell
    localparam int NXT = (j + 1) % K;
    logic sel;
    assign sel = load_en_i && (load_idx_i == IDX_W'(j));

    conv_cell #(.W(W), .ACC_W(ACC_W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .ld_i     (sel),
      .ld_w_i   (load_w_i),
      .ld_tag_i (load_tag_i),
      .step_i   (step),
      .x_i      (sample_i),
      .w_in_i   (w_ring[NXT]),
      .tag_in_i (tag_ring[NXT]),
      .w_o      (w_ring[j]),
      .tag_o    (tag_ring[j]),
      .acc_o    (acc_all[j]),
      .fire_o   (fire[j])
    );
  end

  conv_bus_arb #(.N(K), .ACC_W(ACC_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .acc_i   (acc_all),
    .any_o   (bus_any),
    .data_o  (bus_data),
    .multi_o (bus_multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      collide_o   <= 1'b0;
    end else begin
      out_valid_o <= bus_any;
      collide_o   <= bus_multi;
      if (bus_any) out_data_o <= bus_data;
    end
  end

  // R9: collision flag only accompanies a result
  assert_collide_valid_R9: assert property (@(posedge clk) disable iff (rst)
    collide_o |-> out_valid_o);

  // R8: no result without an accepted sample
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> $past(sample_valid_i && !load_en_i));

  // R2: a load cycle never yields a result
  assert_load_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    load_en_i |=> !out_valid_o);
endmodule

// File: tb/bcast_conv_array_bench.sv
module bcast_conv_array_bench;
  localparam int W     = 8;
  localparam int K     = 4;
  localparam int IDX_W = 2;
  localparam int ACC_W = 2 * W + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst;
  logic                    load_en;
  logic [IDX_W-1:0]        load_idx;
  logic signed [W-1:0]     load_w;
  logic                    load_tag;
  logic                    sample_valid;
  logic signed [W-1:0]     sample;
  logic                    out_valid;
  logic signed [ACC_W-1:0] out_data;
  logic                    collide;

  bcast_conv_array #(.W(W), .K(K)) u_bcast_conv_array (
    .clk            (clk),
    .rst            (rst),
    .load_en_i      (load_en),
    .load_idx_i     (load_idx),
    .load_w_i       (load_w),
    .load_tag_i     (load_tag),
    .sample_valid_i (sample_valid),
    .sample_i       (sample),
    .out_valid_o    (out_valid),
    .out_data_o     (out_data),
    .collide_o      (collide)
  );

  int total = 0;
  int bad   = 0;
  int ws[K];
  int xs[64];
  logic   got_v;
  longint got_d;
  logic   got_c;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint yref(input int i);
    longint s = 0;
    for (int k = 0; k < K; k++) s += longint'(ws[k]) * longint'(xs[i + k]);
    return s;
  endfunction

  task automatic do_reset();
    rst = 1'b1; load_en = 1'b0; load_idx = '0; load_w = '0; load_tag = 1'b0;
    sample_valid = 1'b0; sample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_cell(input int idx, input int w, input bit tag);
    @(negedge clk);
    load_en = 1'b1; load_idx = idx[IDX_W-1:0]; load_w = w[W-1:0]; load_tag = tag;
    @(posedge clk);
    #1;
    load_en = 1'b0; load_tag = 1'b0;
  endtask

  task automatic load_std();
    for (int k = 0; k < K; k++) load_cell(k, ws[k], k == 0);
  endtask

  task automatic push(input int x);
    @(negedge clk);
    sample_valid = 1'b1; sample = x[W-1:0];
    @(posedge clk);
    #1;
    got_v = out_valid; got_d = longint'(out_data); got_c = collide;
    sample_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    @(posedge clk);
    #1;
    got_v = out_valid;
  endtask

  task automatic set_std_weights();
    ws[0] = 3; ws[1] = -5; ws[2] = 7; ws[3] = 2;
  endtask

  // R1: reset state and no output from an unloaded array
  task automatic test_reset();
    do_reset();
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 collide after reset", collide, 0);
    for (int t = 0; t < 6; t++) begin
      push(40 + t);
      chk("R1 no output without load", got_v, 0);
    end
  endtask

  // R3 R4 R5 R6 R7 R8 R2: streaming, optionally with gaps and a blocked load
  task automatic test_stream(input bit gaps, input int n);
    do_reset();
    set_std_weights();
    for (int t = 0; t < 64; t++) xs[t] = ((t * 53 + 17) % 255) - 127;
    load_std();
    for (int t = 0; t < n; t++) begin
      if (gaps && (t % 3 == 1)) begin
        idle_cycle();
        chk("R8 idle gives no output", got_v, 0);
      end
      if (gaps && t == 6) begin
        @(negedge clk);
        load_en = 1'b1; load_idx = '0; load_w = ws[t % K][W-1:0];
        load_tag = (t % K == 0); sample_valid = 1'b1; sample = 8'sd85;
        @(posedge clk);
        #1;
        load_en = 1'b0; load_tag = 1'b0; sample_valid = 1'b0;
        idle_cycle();
        chk("R2 sample ignored during load", got_v, 0);
      end
      push(xs[t]);
      if (t < K) begin
        chk("R7 no output before first finished sum", got_v, 0);
      end else begin
        chk("R6 output valid", got_v, 1);
        chk("R6 R3 R4 R5 convolution value", got_d, yref(t - K));
        chk("R9 no collision with single tag", got_c, 0);
      end
    end
  endtask

  // R10: extreme operands fit the accumulator
  task automatic test_extreme();
    do_reset();
    for (int k = 0; k < K; k++) ws[k] = -128;
    for (int t = 0; t < 64; t++) xs[t] = -128;
    load_std();
    for (int t = 0; t < 8; t++) begin
      push(-128);
      if (t >= K) chk("R10 full-scale sum exact", got_d, 65536);
    end
  endtask

  // R9: two tags, lowest index wins, collision flagged
  task automatic test_collision();
    do_reset();
    set_std_weights();
    xs[0] = 10; xs[1] = -4; xs[2] = 6;
    for (int k = 0; k < K; k++) load_cell(k, ws[k], (k == 0) || (k == 2));
    push(xs[0]);
    chk("R9 no output step 0", got_v, 0);
    push(xs[1]);
    chk("R9 no output step 1", got_v, 0);
    push(xs[2]);
    chk("R9 output on collision", got_v, 1);
    chk("R9 lowest cell wins", got_d, ws[0] * xs[0] + ws[1] * xs[1]);
    chk("R9 collide flag", got_c, 1);
  endtask

  initial begin
    test_reset();
    test_stream(1'b0, 16);
    test_stream(1'b1, 12);
    test_extreme();
    test_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule